// File: doc/BRIEF.md
# SD Card Command Path Controller

This block issues a single card command on the one-bit command line and gathers the card's answer. A host loads a 6-bit command index, a 32-bit argument, a 2-bit response code and two option bits (an abort marker and a busy-wait request), then pulses `launch`. The block frames the 48-bit token (start bit, direction bit, index, argument, CRC7, end bit), drives it out one bit per clock, and then listens on the command input for a short (48-bit) or long (136-bit) answer. The answer's CRC7 is verified when the response code asks for it, and the payload is kept in four 32-bit response words.

After a good answer the block can wait for the card to release data line 0, bounded by a data timer loaded at launch. Every outcome raises a sticky status flag. Flags are cleared by pulsing ones on `flag_clr`, and `irq` reports any flag whose mask bit is set. One clock equals one card clock period.

Top module: `sdc_cmd_path`

## Requirements
- R1: While reset is held and just after it, `flags` is 0, `irq` is 0, `cmd_oe` is 0, `cmd_out` is 1, `cmd_active`, `card_busy` and `abort_req` are 0, and `rsp_data` is 0.
- R2: A `launch` pulse seen while idle drives 48 bits MSB first on `cmd_out`, with `cmd_oe` high, starting the cycle after `launch` is sampled. The bits are 0, 1, the 6-bit index, the 32-bit argument, the CRC7 (polynomial x^7+x^3+1, zero start value) of those first 40 bits, and a closing 1.
- R3: With response code 00 the flag at bit 3 (command sent) is set in the cycle right after the last token bit, and no answer is awaited.
- R4: Response code 01 awaits a 48-bit answer with CRC check, 10 a 48-bit answer without CRC check, and 11 a 136-bit answer whose CRC covers frame bits 127..8. An answer begins when a 0 is sampled on `cmd_in`.
- R5: A valid answer sets the flag at bit 2 (response received). A short answer loads frame bits 39..8 into word 0 (`rsp_data[31:0]`) and leaves the other words unchanged. A long answer loads frame bits 127..96, 95..64, 63..32 and 31..0 into words 0, 1, 2 and 3 (`rsp_data` bits 31:0, 63:32, 95:64 and 127:96).
- R6: A CRC mismatch under codes 01 or 11 sets the flag at bit 0 (CRC fail) instead of bit 2, and the response words stay unchanged. Under code 10 a wrong CRC is accepted.
- R7: If no start bit is sampled in the 64 cycles after the last token bit, the flag at bit 1 (command timeout) is set and the block returns to idle.
- R8: With the busy-wait option set and `dat0_in` low in the cycle after the answer's end bit, `card_busy` goes high. When `dat0_in` is sampled high it drops, and the flag at bit 4 (busy end) is set.
- R9: The busy wait is bounded: with timer value N and `dat0_in` held low, the flag at bit 5 (data timeout) is set on the (N+1)th busy cycle and `card_busy` drops.
- R10: Flags stay set until the matching `flag_clr` bit is pulsed. Clearing one bit leaves the others untouched.
- R11: `irq` is high exactly when some flag and its `flag_mask` bit are both 1.
- R12: `abort_req` is high for the whole of a command launched with `stop_cmd` set, and low once the block is idle.
- R13: A `launch` pulse while `cmd_active` is high has no effect: the token being sent and the awaited answer are those of the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one card bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | Start a command (taken only when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_code | input | 2 | Response kind: 00 none, 01 short+CRC, 10 short raw, 11 long |
| stop_cmd | input | 1 | Marks the command as a data-transfer abort |
| await_busy | input | 1 | Wait on data line 0 after the answer |
| data_timer | input | DT_W | Busy-wait bound in cycles |
| cmd_out | output | 1 | Command line value driven |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line value from the card |
| dat0_in | input | 1 | Data line 0 from the card |
| flag_clr | input | 6 | Write-one-to-clear for the flags |
| flag_mask | input | 6 | Interrupt enables per flag |
| flags | output | 6 | Sticky status flags |
| irq | output | 1 | OR of masked flags |
| rsp_data | output | 128 | Four response words, word 0 lowest |
| cmd_active | output | 1 | A command is in progress |
| card_busy | output | 1 | Waiting for data line 0 release |
| abort_req | output | 1 | Current command is an abort |

## Verification
Tokens are compared bit by bit for two index/argument pairs, including the all-zero command whose CRC is well known. This separates framing and CRC faults from ordering faults. Answers are sent in each of the three response modes, with a right and a wrong CRC, so the tests can tell a missing check apart from a check applied where it must not be, and can show whether words are captured with the wrong alignment. The start bit is placed at the last accepted cycle and one cycle later to pin the timeout window. Data line 0 is released early or held low through the whole timer to pin the busy bound to its exact cycle.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int NFLAG   = 6;
  localparam int FL_CRC  = 0;
  localparam int FL_CTO  = 1;
  localparam int FL_RSP  = 2;
  localparam int FL_SENT = 3;
  localparam int FL_BEND = 4;
  localparam int FL_DTO  = 5;

  typedef enum logic [1:0] {
    RSP_NONE      = 2'b00,
    RSP_SHORT_CRC = 2'b01,
    RSP_SHORT_RAW = 2'b10,
    RSP_LONG      = 2'b11
  } rsp_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_DONE,
    ST_BUSY
  } cp_state_e;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_of40(input logic [39:0] v);
    logic [6:0] c;
    c = 7'h00;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction

endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 import sdc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [6:0] crc
);

  logic [6:0] crc_q, crc_d, base;

  always_comb begin
    base  = clr ? 7'h00 : crc_q;
    crc_d = base;
    if (en) crc_d = crc7_step(base, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 7'h00;
    else if (clr || en) crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/sdc_busy_timer.sv
module sdc_busy_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = load_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  AST_TMR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

endmodule

// File: rtl/sdc_flag_bank.sv
module sdc_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);

  logic [N-1:0] flags_q, flags_d;

  always_comb flags_d = (flags_q & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else flags_q <= flags_d;
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & mask);

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr[i]) |=> flags_q[i]); // R10
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flags_q[i]); // R10
  end

endmodule

// File: rtl/sdc_cmd_path.sv
module sdc_cmd_path import sdc_pkg::*; #(
  parameter int RSP_TIMEOUT = 64,
  parameter int DT_W        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [5:0]       cmd_idx,
  input  logic [31:0]      cmd_arg,
  input  logic [1:0]       rsp_code,
  input  logic             stop_cmd,
  input  logic             await_busy,
  input  logic [DT_W-1:0]  data_timer,
  output logic             cmd_out,
  output logic             cmd_oe,
  input  logic             cmd_in,
  input  logic             dat0_in,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic [NFLAG-1:0] flag_mask,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic [127:0]     rsp_data,
  output logic             cmd_active,
  output logic             card_busy,
  output logic             abort_req
);

  localparam int TOK_LEN   = 48;
  localparam int SHORT_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int WORD_W    = 32;
  localparam int NWORD     = 4;
  localparam int SR_W      = WORD_W * NWORD;
  localparam int CNT_W     = $clog2(LONG_LEN + 1);
  localparam int TO_W      = $clog2(RSP_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] TOK_LAST   = CNT_W'(TOK_LEN - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);
  localparam logic [CNT_W-1:0] SHORT_CRC_END = CNT_W'(39);
  localparam logic [CNT_W-1:0] LONG_CRC_BEG  = CNT_W'(8);
  localparam logic [CNT_W-1:0] LONG_CRC_END  = CNT_W'(127);
  localparam logic [TO_W-1:0]  TO_LAST = TO_W'(RSP_TIMEOUT - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  cp_state_e        st_q, st_d;
  logic [TOK_LEN-1:0] tx_sr_q, tx_sr_d;
  logic [SR_W-1:0]  rx_sr_q, rx_sr_d;
  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic [TO_W-1:0]  to_cnt_q, to_cnt_d;
  logic [1:0]       code_q, code_d;
  logic             busy_en_q, busy_en_d;
  logic             stop_q, stop_d;
  logic [DT_W-1:0]  dt_q, dt_d;

  logic [NFLAG-1:0] flag_set;
  logic             crc_clr, crc_en, rsp_load, tmr_load, tmr_dec, tmr_zero;
  logic [6:0]       crc_val;
  logic             long_q, check_q, covered;
  logic [CNT_W-1:0] frame_last;

  assign long_q     = (code_q == RSP_LONG);
  assign check_q    = (code_q == RSP_SHORT_CRC) || (code_q == RSP_LONG);
  assign frame_last = long_q ? LONG_LAST : SHORT_LAST;
  assign covered    = long_q ? (bit_cnt_q >= LONG_CRC_BEG && bit_cnt_q <= LONG_CRC_END)
                             : (bit_cnt_q <= SHORT_CRC_END);

  always_comb begin
    st_d      = st_q;
    tx_sr_d   = tx_sr_q;
    rx_sr_d   = rx_sr_q;
    bit_cnt_d = bit_cnt_q;
    to_cnt_d  = to_cnt_q;
    code_d    = code_q;
    busy_en_d = busy_en_q;
    stop_d    = stop_q;
    dt_d      = dt_q;
    flag_set  = '0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    rsp_load  = 1'b0;
    tmr_load  = 1'b0;
    tmr_dec   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (launch) begin
          tx_sr_d   = {2'b01, cmd_idx, cmd_arg, crc7_of40({2'b01, cmd_idx, cmd_arg}), 1'b1};
          bit_cnt_d = '0;
          code_d    = rsp_code;
          busy_en_d = await_busy;
          stop_d    = stop_cmd;
          dt_d      = data_timer;
          st_d      = ST_SEND;
        end
      end
      ST_SEND: begin
        tx_sr_d   = {tx_sr_q[TOK_LEN-2:0], 1'b1};
        bit_cnt_d = bit_cnt_q + 1'b1;
        if (bit_cnt_q == TOK_LAST) begin
          if (code_q == RSP_NONE) begin
            flag_set[FL_SENT] = 1'b1;
            st_d = ST_IDLE;
          end else begin
            to_cnt_d = '0;
            st_d     = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!cmd_in) begin
          rx_sr_d   = {rx_sr_q[SR_W-2:0], cmd_in};
          bit_cnt_d = CNT_W'(1);
          crc_clr   = 1'b1;
          crc_en    = !long_q;
          st_d      = ST_RECV;
        end else if (to_cnt_q == TO_LAST) begin
          flag_set[FL_CTO] = 1'b1;
          st_d = ST_IDLE;
        end else begin
          to_cnt_d = to_cnt_q + 1'b1;
        end
      end
      ST_RECV: begin
        rx_sr_d   = {rx_sr_q[SR_W-2:0], cmd_in};
        bit_cnt_d = bit_cnt_q + 1'b1;
        crc_en    = covered;
        if (bit_cnt_q == frame_last) st_d = ST_DONE;
      end
      ST_DONE: begin
        if (check_q && (crc_val != rx_sr_q[7:1])) begin
          flag_set[FL_CRC] = 1'b1;
          st_d = ST_IDLE;
        end else begin
          flag_set[FL_RSP] = 1'b1;
          rsp_load = 1'b1;
          if (busy_en_q && !dat0_in) begin
            tmr_load = 1'b1;
            st_d     = ST_BUSY;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_BUSY: begin
        if (dat0_in) begin
          flag_set[FL_BEND] = 1'b1;
          st_d = ST_IDLE;
        end else if (tmr_zero) begin
          flag_set[FL_DTO] = 1'b1;
          st_d = ST_IDLE;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q      <= ST_IDLE;
      tx_sr_q   <= '1;
      rx_sr_q   <= '0;
      bit_cnt_q <= '0;
      to_cnt_q  <= '0;
      code_q    <= RSP_NONE;
      busy_en_q <= 1'b0;
      stop_q    <= 1'b0;
      dt_q      <= '0;
    end else begin
      st_q      <= st_d;
      tx_sr_q   <= tx_sr_d;
      rx_sr_q   <= rx_sr_d;
      bit_cnt_q <= bit_cnt_d;
      to_cnt_q  <= to_cnt_d;
      code_q    <= code_d;
      busy_en_q <= busy_en_d;
      stop_q    <= stop_d;
      dt_q      <= dt_d;
    end
  end

  // response word capture
  logic [WORD_W-1:0] rsp_w_q [NWORD];
  for (genvar k = 0; k < NWORD; k++) begin : g_word
    logic [WORD_W-1:0] w_d;
    always_comb begin
      w_d = rsp_w_q[k];
      if (rsp_load) begin
        if (long_q) w_d = rx_sr_q[SR_W-1-WORD_W*k -: WORD_W];
        else if (k == 0) w_d = rx_sr_q[39:8];
      end
    end
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) rsp_w_q[k] <= '0;
      else if (rsp_load) rsp_w_q[k] <= w_d;
    end
    assign rsp_data[WORD_W*k +: WORD_W] = rsp_w_q[k];
  end

  sdc_crc7 u_crc (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (cmd_in),
    .crc   (crc_val)
  );

  sdc_busy_timer #(.W(DT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (tmr_load),
    .load_val (dt_q),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  sdc_flag_bank #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n_s),
    .set   (flag_set),
    .clr   (flag_clr),
    .mask  (flag_mask),
    .flags (flags),
    .irq   (irq)
  );

  assign cmd_oe     = (st_q == ST_SEND);
  assign cmd_out    = (st_q == ST_SEND) ? tx_sr_q[TOK_LEN-1] : 1'b1;
  assign cmd_active = (st_q != ST_IDLE);
  assign card_busy  = (st_q == ST_BUSY);
  assign abort_req  = stop_q && (st_q != ST_IDLE);

  AST_TOKEN_LEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(cmd_oe) |-> ($past(bit_cnt_q) == TOK_LAST)); // R2
  AST_SENT_NORSP: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(flags[FL_SENT]) |-> ($past(code_q) == RSP_NONE)); // R3
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_WAIT && !cmd_in) |=> (st_q == ST_RECV)); // R7
  AST_CTO_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(flags[FL_CTO]) |-> ($past(st_q) == ST_WAIT)); // R7
  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(card_busy) |-> ($past(busy_en_q) && !$past(dat0_in))); // R8
  AST_LAUNCH_HELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q != ST_IDLE && launch) |=> (code_q == $past(code_q))); // R13

endmodule

// File: tb/sdc_cmd_path_tb.sv
module sdc_cmd_path_tb_top;
  import sdc_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, launch, stop_cmd, await_busy, cmd_out, cmd_oe, cmd_in, dat0_in;
  logic irq, cmd_active, card_busy, abort_req;
  logic [5:0] cmd_idx, flag_clr, flag_mask, flags;
  logic [31:0] cmd_arg, data_timer;
  logic [1:0] rsp_code;
  logic [127:0] rsp_data;

  int tot = 0;
  int bad = 0;

  sdc_cmd_path dut_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .rsp_code(rsp_code), .stop_cmd(stop_cmd), .await_busy(await_busy),
    .data_timer(data_timer), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in),
    .dat0_in(dat0_in), .flag_clr(flag_clr), .flag_mask(flag_mask), .flags(flags),
    .irq(irq), .rsp_data(rsp_data), .cmd_active(cmd_active), .card_busy(card_busy),
    .abort_req(abort_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; tot++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] bcrc(input logic [119:0] v, input int n);
    logic [6:0] c = 7'h00;
    for (int i = n - 1; i >= 0; i--) begin
      logic f = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (f) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_tok(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, bcrc({80'h0, 2'b01, idx, arg}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] pay, input bit corrupt);
    logic [6:0] c = bcrc({80'h0, 2'b00, idx, pay}, 40) ^ {6'd0, corrupt};
    return {88'h0, 2'b00, idx, pay, c, 1'b1};
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] body, input bit corrupt);
    logic [6:0] c = bcrc(body, 120) ^ {6'd0, corrupt};
    return {2'b00, 6'h3F, body, c, 1'b1};
  endfunction

  task automatic clear_all();
    flag_clr = 6'h3F; @(negedge clk); flag_clr = 6'h00;
  endtask

  // launches and checks the token; leaves the bench at the negedge after the last bit
  task automatic send(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] code,
                      input bit bw, input bit stp, input logic [31:0] dt, input bit poke);
    logic [47:0] got = '0;
    logic [47:0] exp = mk_tok(idx, arg);
    bit oe_ok = 1'b1;
    bit ab0 = 1'b0;
    cmd_idx = idx; cmd_arg = arg; rsp_code = code; await_busy = bw; stop_cmd = stp; data_timer = dt;
    launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
    for (int b = 0; b < 48; b++) begin
      got = {got[46:0], cmd_out};
      if (!cmd_oe) oe_ok = 1'b0;
      if (b == 0) ab0 = abort_req;
      if (poke && b == 10) begin
        launch = 1'b1; cmd_idx = ~idx; cmd_arg = ~arg; rsp_code = RSP_NONE;
      end
      if (poke && b == 11) launch = 1'b0;
      @(negedge clk);
    end
    cmd_idx = idx; cmd_arg = arg; rsp_code = code;
    chk(got == exp && oe_ok, poke ? "R13 token kept" : "R2 token", {80'h0, got}, {80'h0, exp});
    chk(cmd_oe == 1'b0, "R2 oe low after token", {127'h0, cmd_oe}, 0);
    if (stp) chk(ab0 == 1'b1, "R12 abort during command", {127'h0, ab0}, 1);
  endtask

  task automatic drive(input logic [135:0] fr, input int len, input int gap);
    for (int g = 0; g < gap; g++) begin cmd_in = 1'b1; @(negedge clk); end
    for (int i = len - 1; i >= 0; i--) begin cmd_in = fr[i]; @(negedge clk); end
    cmd_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; launch = 0; stop_cmd = 0; await_busy = 0; cmd_in = 1; dat0_in = 1;
    cmd_idx = 0; cmd_arg = 0; rsp_code = 0; data_timer = 0; flag_clr = 0; flag_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(flags == 0 && irq == 0, "R1 flags/irq", {122'h0, flags}, 0);
    chk(cmd_oe == 0 && cmd_out == 1, "R1 line idle", {126'h0, cmd_oe, cmd_out}, 1);
    chk(!cmd_active && !card_busy && !abort_req, "R1 status", {125'h0, cmd_active, card_busy, abort_req}, 0);
    chk(rsp_data == 0, "R1 rsp_data", rsp_data, 0);
  endtask

  task automatic t_no_resp();
    clear_all();
    send(6'd0, 32'h0, RSP_NONE, 0, 0, 0, 0);
    chk(flags == 6'b001000, "R3 sent flag", {122'h0, flags}, 6'b001000);
    chk(!cmd_active, "R3 idle after send", {127'h0, cmd_active}, 0);
    flag_mask = 6'b001000; #1;
    chk(irq == 1'b1, "R11 irq masked in", {127'h0, irq}, 1);
    flag_mask = 6'b110111; #1;
    chk(irq == 1'b0, "R11 irq masked out", {127'h0, irq}, 0);
    flag_mask = 0;
  endtask

  task automatic t_short(input logic [1:0] code, input logic [31:0] pay, input bit corrupt,
                         input bit expect_ok, input logic [31:0] exp_w0, input string tag);
    clear_all();
    send(6'd17, 32'h1234_5678, code, 0, 0, 0, 0);
    drive(mk_short(6'd17, pay, corrupt), 48, 5);
    chk(flags == (expect_ok ? 6'b000100 : 6'b000001), {tag, " flag"}, {122'h0, flags},
        expect_ok ? 6'b000100 : 6'b000001);
    chk(rsp_data[31:0] == exp_w0, {tag, " word0"}, {96'h0, rsp_data[31:0]}, {96'h0, exp_w0});
  endtask

  task automatic t_long(input bit corrupt, input logic [127:0] exp_prev);
    logic [119:0] body = 120'hA5_0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2;
    logic [135:0] fr = mk_long(body, corrupt);
    logic [127:0] exp = corrupt ? exp_prev : {fr[31:0], fr[63:32], fr[95:64], fr[127:96]};
    clear_all();
    send(6'd2, 32'h0, RSP_LONG, 0, 0, 0, 0);
    drive(fr, 136, 3);
    chk(flags == (corrupt ? 6'b000001 : 6'b000100), corrupt ? "R6 long bad crc" : "R5 long ok",
        {122'h0, flags}, corrupt ? 6'b000001 : 6'b000100);
    chk(rsp_data == exp, corrupt ? "R6 long words kept" : "R5 long words", rsp_data, exp);
  endtask

  task automatic t_timeout();
    clear_all();
    send(6'd8, 32'h1AA, RSP_SHORT_CRC, 0, 0, 0, 0);
    drive(mk_short(6'd8, 32'h0000_01AA, 0), 48, 63);
    chk(flags == 6'b000100, "R7 start at last cycle", {122'h0, flags}, 6'b000100);
    clear_all();
    send(6'd8, 32'h1AA, RSP_SHORT_CRC, 0, 0, 0, 0);
    repeat (63) @(negedge clk);
    chk(flags[FL_CTO] == 0 && cmd_active, "R7 no timeout yet", {126'h0, flags[FL_CTO], cmd_active}, 1);
    @(negedge clk);
    chk(flags == 6'b000010 && !cmd_active, "R7 timeout", {122'h0, flags}, 6'b000010);
  endtask

  task automatic t_busy_end();
    clear_all();
    dat0_in = 1'b0;
    send(6'd7, 32'h0001_0000, RSP_SHORT_CRC, 1, 0, 32'd100, 0);
    drive(mk_short(6'd7, 32'h0000_0700, 0), 48, 2);
    chk(card_busy && flags == 6'b000100, "R8 busy seen", {122'h0, flags} | {card_busy, 127'h0}, {1'b1, 121'h0, 6'b000100});
    repeat (3) @(negedge clk);
    dat0_in = 1'b1;
    @(negedge clk);
    chk(!card_busy && flags == 6'b010100, "R8 busy end", {122'h0, flags}, 6'b010100);
  endtask

  task automatic t_busy_timeout();
    clear_all();
    dat0_in = 1'b0;
    send(6'd7, 32'h0, RSP_SHORT_CRC, 1, 0, 32'd5, 0);
    drive(mk_short(6'd7, 32'h0000_0900, 0), 48, 2);
    repeat (5) @(negedge clk);
    chk(card_busy && !flags[FL_DTO], "R9 before bound", {126'h0, card_busy, flags[FL_DTO]}, 2);
    @(negedge clk);
    chk(!card_busy && flags == 6'b100100, "R9 data timeout", {122'h0, flags}, 6'b100100);
    dat0_in = 1'b1;
  endtask

  task automatic t_clear();
    repeat (4) @(negedge clk);
    chk(flags == 6'b100100, "R10 flags stick", {122'h0, flags}, 6'b100100);
    flag_clr = 6'b100000; @(negedge clk); flag_clr = 0;
    chk(flags == 6'b000100, "R10 single clear", {122'h0, flags}, 6'b000100);
    flag_mask = 6'b000100; #1;
    chk(irq == 1'b1, "R11 irq after clear", {127'h0, irq}, 1);
    flag_mask = 0;
  endtask

  task automatic t_stop();
    clear_all();
    send(6'd12, 32'h0, RSP_NONE, 0, 1, 0, 0);
    chk(abort_req == 0 && flags == 6'b001000, "R12 abort drops", {127'h0, abort_req}, 0);
  endtask

  task automatic t_poke();
    clear_all();
    send(6'd13, 32'h0BEE_0000, RSP_SHORT_CRC, 0, 0, 0, 1);
    drive(mk_short(6'd13, 32'h5555_AAAA, 0), 48, 1);
    chk(flags == 6'b000100, "R13 response still awaited", {122'h0, flags}, 6'b000100);
    chk(rsp_data[31:0] == 32'h5555_AAAA, "R13 word0", {96'h0, rsp_data[31:0]}, 32'h5555_AAAA);
  endtask

  initial begin
    logic [127:0] long_prev;
    t_reset();
    t_no_resp();
    t_short(RSP_SHORT_CRC, 32'hCAFE_F00D, 0, 1, 32'hCAFE_F00D, "R5 short ok");
    t_short(RSP_SHORT_CRC, 32'h1111_2222, 1, 0, 32'hCAFE_F00D, "R6 short bad crc");
    t_short(RSP_SHORT_RAW, 32'h0BAD_BEEF, 1, 1, 32'h0BAD_BEEF, "R4 raw accepts bad crc");
    t_long(0, 128'h0);
    long_prev = rsp_data;
    t_long(1, long_prev);
    t_timeout();
    t_busy_end();
    t_busy_timeout();
    t_clear();
    t_stop();
    t_poke();
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

endmodule